// File: doc/BRIEF.md
# Prioritized Exception Controller with Pending Latch

This block decides which exception a processor core takes in each cycle. It accepts requests from four sources: the release of the active-low reset pin, a watchdog overrun, a group of four error lines that share one entry, and an overflow from extended arithmetic. Each cycle it raises at most one single-cycle trap strobe, together with an entry vector index. Reset always wins. Errors come next, and the arithmetic overflow comes last.

A reset trap pulses a flush to the load/store pipeline control and sets the bus, function and memory control registers to all ones. The overflow exception is enabled only while bit 16 of the function control register is zero. When an enabled overflow is blocked, either by a higher-priority request or by the core's interrupt-lock flag, it is held in a sticky pending flag. The trap then fires in the first cycle in which nothing blocks it.

A two-state machine gates all of this. `ST_BOOT` is entered while the reset pin is low, and in it only a reset source can produce a trap. The transition `boot_done` moves to `ST_RUN` on the first reset trap, and `ST_RUN` then holds until the pin is pulled low again.

Top module: `trap_prio_ctrl`

## Requirements
- R1: A reset trap (vector 0) is raised when the reset pin rises: it is sampled through two synchronizer flops and an edge flop, so `trap_o` is high in the third cycle after release. A reset trap is also raised in the cycle after `wdog_ovr_i` is high.
- R2: Priority is reset, then error, then overflow. Only the highest-priority pending source traps in a given cycle, and `trap_o` is a one-cycle pulse per taken exception.
- R3: While the pin is low, and from the cycle of any reset trap, `bcr_o`, `fcr_o` and `mcr_o` read all ones. A reset trap also discards a pending overflow.
- R4: `flush_o` is high exactly in the cycle of a reset trap and in no other cycle.
- R5: Any of the four lines of `err_req_i` in the run state, with no reset source, gives a trap with vector 1 in the next cycle.
- R6: An enabled, unblocked `xovf_req_i` gives a trap with vector 2 in the next cycle.
- R7: An overflow request while `fcr_o[16]` is 1 is ignored and is not remembered.
- R8: An enabled overflow blocked by `lock_i`, by an error or by a reset-free higher-priority trap becomes pending. Its vector-2 trap is raised in the cycle after the first cycle with no blocker.
- R9: A write through `fcr_we_i` loads `fcr_wdata_i` into `fcr_o` in the next cycle. A write with bit 16 set clears a pending overflow, and that clear wins over a take in the same cycle.
- R10: When a pending overflow is taken in the same cycle that a new enabled request arrives, the flag stays set, and a second vector-2 trap follows in the next unblocked cycle.
- R11: In `ST_BOOT`, error and overflow requests produce no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low reset pin; low clears the block, rise requests a reset trap |
| wdog_ovr_i | input | 1 | Watchdog overrun, requests a reset trap |
| err_req_i | input | 4 | Range, pointer, frame and privilege error requests |
| xovf_req_i | input | 1 | Extended arithmetic overflow request |
| lock_i | input | 1 | Interrupt-lock flag, blocks the overflow trap |
| fcr_we_i | input | 1 | Function control register write enable |
| fcr_wdata_i | input | 32 | Function control register write data |
| trap_o | output | 1 | One-cycle trap strobe |
| vec_o | output | 2 | Entry vector: 0 reset, 1 error group, 2 overflow |
| flush_o | output | 1 | Load/store pipeline flush pulse |
| bcr_o | output | 32 | Bus control register |
| fcr_o | output | 32 | Function control register |
| mcr_o | output | 32 | Memory control register |

## Verification
Two functions meet in the same cycle: arbitration between sources, and latching of the pending overflow. The bench raises an error and an overflow together. It then checks that the error trap comes first and that the overflow follows by itself one cycle later. It also raises a watchdog overrun alongside an error, a fresh overflow and an already pending overflow. Here exactly one reset trap is expected, with registers at all ones and no trap afterwards. A scoreboard queue holds the expected vectors in order, so any extra, missing or reordered trap is reported.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        VEC_RESET = 2'd0,
        VEC_ERROR = 2'd1,
        VEC_XOVF  = 2'd2
    } trap_vec_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/trap_edge_sync.sv
module trap_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic rise_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge pin_n) begin
                if (!pin_n) sync_q <= '0;
                else        sync_q <= 1'b1;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge pin_n) begin
                if (!pin_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign rise_o = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/trap_ovf_pend.sv
module trap_ovf_pend (
    input  logic clk,
    input  logic arst_n,
    input  logic ovf_now_i,
    input  logic take_i,
    input  logic clear_i,
    output logic pend_o
);
    logic pend_q;
    logic pend_d;

    always_comb begin
        if (clear_i)     pend_d = 1'b0;
        else if (take_i) pend_d = pend_q & ovf_now_i;
        else             pend_d = pend_q | ovf_now_i;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pend_q <= 1'b0;
        else         pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/trap_ctl_regs.sv
module trap_ctl_regs #(
    parameter int REG_W   = 32,
    parameter int OVF_BIT = 16
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             set_all_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] bcr_o,
    output logic [REG_W-1:0] fcr_o,
    output logic [REG_W-1:0] mcr_o,
    output logic             ovf_en_o
);
    localparam logic [REG_W-1:0] ALL_ONES = {REG_W{1'b1}};

    logic [REG_W-1:0] bcr_q;
    logic [REG_W-1:0] fcr_q;
    logic [REG_W-1:0] mcr_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            bcr_q <= ALL_ONES;
            mcr_q <= ALL_ONES;
        end else if (set_all_i) begin
            bcr_q <= ALL_ONES;
            mcr_q <= ALL_ONES;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)        fcr_q <= ALL_ONES;
        else if (set_all_i) fcr_q <= ALL_ONES;
        else if (wr_en_i)   fcr_q <= wr_data_i;
    end

    assign bcr_o    = bcr_q;
    assign fcr_o    = fcr_q;
    assign mcr_o    = mcr_q;
    assign ovf_en_o = ~fcr_q[OVF_BIT];
endmodule

// File: rtl/trap_prio_ctrl.sv
module trap_prio_ctrl
    import trap_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter int OVF_BIT     = 16,
    parameter int ERR_LINES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_pin_n,
    input  logic                 wdog_ovr_i,
    input  logic [ERR_LINES-1:0] err_req_i,
    input  logic                 xovf_req_i,
    input  logic                 lock_i,
    input  logic                 fcr_we_i,
    input  logic [REG_W-1:0]     fcr_wdata_i,
    output logic                 trap_o,
    output logic [1:0]           vec_o,
    output logic                 flush_o,
    output logic [REG_W-1:0]     bcr_o,
    output logic [REG_W-1:0]     fcr_o,
    output logic [REG_W-1:0]     mcr_o
);
    ctl_state_e state_q;
    ctl_state_e state_d;

    logic      pin_rise;
    logic      rst_req;
    logic      err_any;
    logic      run;
    logic      ovf_en;
    logic      ovf_now;
    logic      pend;
    logic      clr_by_wr;
    logic      take_ovf;
    logic      trap_q;
    logic      flush_q;
    trap_vec_e vec_q;

    trap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .pin_n  (rst_pin_n),
        .rise_o (pin_rise)
    );

    // Request decode, evaluated in the decision cycle
    assign rst_req   = pin_rise | wdog_ovr_i;
    assign err_any   = |err_req_i;
    assign run       = (state_q == ST_RUN);
    assign ovf_now   = run & xovf_req_i & ovf_en;
    assign clr_by_wr = fcr_we_i & fcr_wdata_i[OVF_BIT];
    assign take_ovf  = run & (pend | ovf_now) & ~rst_req & ~err_any
                     & ~lock_i & ~clr_by_wr;

    trap_ovf_pend u_pend (
        .clk       (clk),
        .arst_n    (rst_pin_n),
        .ovf_now_i (ovf_now),
        .take_i    (take_ovf),
        .clear_i   (rst_req | clr_by_wr),
        .pend_o    (pend)
    );

    trap_ctl_regs #(.REG_W(REG_W), .OVF_BIT(OVF_BIT)) u_regs (
        .clk       (clk),
        .arst_n    (rst_pin_n),
        .set_all_i (rst_req),
        .wr_en_i   (fcr_we_i),
        .wr_data_i (fcr_wdata_i),
        .bcr_o     (bcr_o),
        .fcr_o     (fcr_o),
        .mcr_o     (mcr_o),
        .ovf_en_o  (ovf_en)
    );

    // Next-state: boot_done on the first reset trap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (rst_req) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) state_q <= ST_BOOT;
        else            state_q <= state_d;
    end

    // Output register: one trap per cycle, fixed priority
    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            trap_q  <= 1'b0;
            flush_q <= 1'b0;
            vec_q   <= VEC_RESET;
        end else begin
            flush_q <= rst_req;
            if (rst_req) begin
                trap_q <= 1'b1;
                vec_q  <= VEC_RESET;
            end else if (run && err_any) begin
                trap_q <= 1'b1;
                vec_q  <= VEC_ERROR;
            end else if (take_ovf) begin
                trap_q <= 1'b1;
                vec_q  <= VEC_XOVF;
            end else begin
                trap_q <= 1'b0;
                vec_q  <= VEC_RESET;
            end
        end
    end

    assign trap_o  = trap_q;
    assign flush_o = flush_q;
    assign vec_o   = vec_q;
endmodule

// File: rtl/trap_prio_ctrl_chk.sv
module trap_prio_ctrl_chk #(
    parameter int REG_W   = 32,
    parameter int OVF_BIT = 16
) (
    input logic             clk,
    input logic             rst_pin_n,
    input logic             wdog_ovr_i,
    input logic             lock_i,
    input logic             trap_o,
    input logic [1:0]       vec_o,
    input logic             flush_o,
    input logic [REG_W-1:0] bcr_o,
    input logic [REG_W-1:0] fcr_o,
    input logic [REG_W-1:0] mcr_o
);
    AST_WDOG_RESET: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ($past(rst_pin_n) && $past(wdog_ovr_i)) |-> (trap_o && vec_o == 2'd0)); // R1

    AST_FLUSH_ONLY_RESET: assert property (@(posedge clk) disable iff (!rst_pin_n)
        flush_o |-> (trap_o && vec_o == 2'd0)); // R4

    AST_RESET_REGS_ONES: assert property (@(posedge clk) disable iff (!rst_pin_n)
        flush_o |-> (&bcr_o && &fcr_o && &mcr_o)); // R3

    AST_LOCK_BLOCKS_OVF: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ($past(rst_pin_n) && $past(lock_i) && trap_o) |-> (vec_o != 2'd2)); // R8

    AST_DISABLED_NO_OVF: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ($past(rst_pin_n) && trap_o && vec_o == 2'd2) |-> !$past(fcr_o[OVF_BIT])); // R7
endmodule

bind trap_prio_ctrl trap_prio_ctrl_chk #(.REG_W(REG_W), .OVF_BIT(OVF_BIT)) u_chk (
    .clk        (clk),
    .rst_pin_n  (rst_pin_n),
    .wdog_ovr_i (wdog_ovr_i),
    .lock_i     (lock_i),
    .trap_o     (trap_o),
    .vec_o      (vec_o),
    .flush_o    (flush_o),
    .bcr_o      (bcr_o),
    .fcr_o      (fcr_o),
    .mcr_o      (mcr_o)
);

// File: tb/trap_prio_ctrl_bench.sv
`timescale 1ns/1ps
module trap_prio_ctrl_bench;
    localparam logic [1:0] V_RST = 2'd0;
    localparam logic [1:0] V_ERR = 2'd1;
    localparam logic [1:0] V_OVF = 2'd2;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_pin_n = 1'b0;
    logic        wdog = 1'b0;
    logic [3:0]  err = 4'h0;
    logic        ovf = 1'b0;
    logic        lock = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic        trap_o, flush_o;
    logic [1:0]  vec_o;
    logic [31:0] bcr_o, fcr_o, mcr_o;

    typedef struct { logic [1:0] vec; string tag; } exp_t;
    exp_t exp_q[$];
    exp_t got;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    trap_prio_ctrl u_trap_prio_ctrl (
        .clk(clk), .rst_pin_n(rst_pin_n), .wdog_ovr_i(wdog), .err_req_i(err),
        .xovf_req_i(ovf), .lock_i(lock), .fcr_we_i(we), .fcr_wdata_i(wdata),
        .trap_o(trap_o), .vec_o(vec_o), .flush_o(flush_o),
        .bcr_o(bcr_o), .fcr_o(fcr_o), .mcr_o(mcr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_trap(input logic [1:0] v, input string tag);
        exp_t e;
        e.vec = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Drive one cycle of request inputs, then clear them
    task automatic cyc(input logic w, input logic [3:0] e, input logic o);
        wdog = w; err = e; ovf = o;
        @(negedge clk);
        wdog = 1'b0; err = 4'h0; ovf = 1'b0;
    endtask

    task automatic wr_fcr(input logic [31:0] d);
        we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Monitor: every trap must match the head of the queue
    always @(negedge clk) begin
        if (rst_pin_n === 1'b1 && !done) begin
            if (trap_o === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected trap", vec_o, 32'hX);
                end else begin
                    got = exp_q.pop_front();
                    chk(vec_o === got.vec, got.tag, vec_o, got.vec);
                    chk(flush_o === (got.vec == V_RST), "R4 flush", flush_o, got.vec == V_RST);
                end
            end else if (flush_o !== 1'b0) begin
                chk(1'b0, "R4 flush without trap", flush_o, 0);
            end
        end
    end

    task automatic report();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset state while the pin is low
        chk(trap_o === 1'b0 && flush_o === 1'b0, "R3 idle outputs in reset", trap_o, 0);
        chk(bcr_o === ONES && fcr_o === ONES && mcr_o === ONES, "R3 regs in reset", fcr_o, ONES);

        // R1 pin release; R11 errors ignored during boot
        rst_pin_n = 1'b1;
        err = 4'hF;
        expect_trap(V_RST, "R1 pin release");
        @(negedge clk);
        @(negedge clk);
        err = 4'h0;
        drain("R11 no trap in boot");
        chk(fcr_o === ONES && bcr_o === ONES && mcr_o === ONES, "R3 regs after reset trap", fcr_o, ONES);

        // R9 write, overflow enabled (bit 16 clear)
        wr_fcr(32'hA5A4_0F0F);
        chk(fcr_o === 32'hA5A4_0F0F, "R9 fcr write", fcr_o, 32'hA5A4_0F0F);

        // R5 each error line
        for (int i = 0; i < 4; i++) begin
            expect_trap(V_ERR, "R5 error line");
            cyc(1'b0, 4'(1 << i), 1'b0);
        end
        drain("R5 error traps");

        // R6 plain overflow
        expect_trap(V_OVF, "R6 overflow");
        cyc(1'b0, 4'h0, 1'b1);
        drain("R6 overflow trap");

        // R7 disabled overflow ignored and not remembered
        wr_fcr(32'h0001_0000);
        cyc(1'b0, 4'h0, 1'b1);
        wr_fcr(32'h0000_0000);
        drain("R7 disabled overflow");

        // R8 blocked by lock, taken on release
        lock = 1'b1;
        cyc(1'b0, 4'h0, 1'b1);
        drain("R8 held while locked");
        expect_trap(V_OVF, "R8 released lock");
        lock = 1'b0;
        drain("R8 pending taken");

        // R2 error and overflow together: error first, then overflow
        expect_trap(V_ERR, "R2 error over overflow");
        expect_trap(V_OVF, "R8 overflow after error");
        cyc(1'b0, 4'b0010, 1'b1);
        drain("R2 coincident");

        // R9 clear pending by disabling write
        lock = 1'b1;
        cyc(1'b0, 4'h0, 1'b1);
        wr_fcr(32'h0001_0000);
        wr_fcr(32'h0000_0000);
        lock = 1'b0;
        drain("R9 pending cleared");

        // R10 take pending and re-arm in the same cycle
        lock = 1'b1;
        cyc(1'b0, 4'h0, 1'b1);
        expect_trap(V_OVF, "R10 first");
        expect_trap(V_OVF, "R10 second");
        lock = 1'b0;
        cyc(1'b0, 4'h0, 1'b1);
        drain("R10 re-arm");

        // R1 watchdog with error, overflow and pending: one reset trap only
        lock = 1'b1;
        cyc(1'b0, 4'h0, 1'b1);
        lock = 1'b0;
        expect_trap(V_RST, "R1 watchdog");
        cyc(1'b1, 4'b0001, 1'b1);
        drain("R2 reset overrides all");
        chk(fcr_o === ONES && bcr_o === ONES && mcr_o === ONES, "R3 regs after watchdog", fcr_o, ONES);
        cyc(1'b0, 4'h0, 1'b1);
        drain("R7 disabled after reset");

        report();
    end
endmodule